// File: doc/BRIEF.md
# Serial Flash Subsector Erase Sequencer

This block runs on the host side and erases one subsector of an external serial configuration flash. The flash is reached over a single-data-line serial link: a clock, an active-low chip select, one command/data output and one status input. A one-cycle start pulse hands the block a target address and an address-width select (24-bit or 32-bit). From then on the block works alone. It first sends a write-enable command in its own transaction. It then sends the subsector erase command with the chosen address. Last, it waits for the flash's internal erase to finish.

There are two ways to wait. In polling mode the block issues status-read transactions until the write-in-progress bit reads 0. A programmable limit on the number of reads ends the sequence with a timeout flag if the bit never clears. In fixed-wait mode the block skips status reads and counts a programmed number of system clocks after the erase command. In both modes the block reports completion with a one-cycle done pulse.

Any address inside the wanted subsector selects that subsector. The address is passed to the flash unchanged. The serial clock runs at the system clock divided by twice the `CLK_DIV` parameter. Chip select stays high for at least `GAP_CYC` system clocks between transactions.

Top module: `ssec_erase_seq`

## Requirements
- R1: After an accepted start, the first transaction carries only the write-enable opcode 0x06 (8 serial clocks). The erase command follows in a separate transaction, with chip select returning high in between.
- R2: The erase transaction shifts opcode 0x20 and then the address, all MSB first. With `four_byte`=0 the address is `addr[23:0]` (32 serial clocks in total). With `four_byte`=1 it is `addr[31:0]` (40 serial clocks). Every address bit, low bits included, is sent unchanged.
- R3: `spi_clk` idles low while `spi_cs_n` is high. `spi_mosi` changes only while `spi_clk` is low. `spi_miso` is sampled at the rising edge of `spi_clk`. A transaction has exactly as many serial clocks as it has bits, and chip select rises after the last falling edge.
- R4: Chip select stays high for at least `GAP_CYC` system clocks between any two transactions.
- R5: With `fixed_wait`=0, after the erase the block issues status reads. Each read is opcode 0x05 followed by 8 bits taken from `spi_miso`, MSB first, making 16 serial clocks. Status bit 0 (the last bit received) is write-in-progress. Reads repeat while that bit is 1. The first read that returns 0 ends the sequence with `timed_out`=0.
- R6: If write-in-progress still reads 1 on the read that brings the count to `poll_limit`, the sequence ends with `timed_out`=1. A `poll_limit` of 0 acts as 1. `timed_out` holds until the next accepted start, and the limit is captured at start.
- R7: With `fixed_wait`=1, no status read is issued. `done` comes at least `wait_cycles` system clocks after chip select rises at the end of the erase.
- R8: `busy` is high from the cycle after an accepted start until `done`. `done` is a one-cycle pulse while `busy` is low. A start while `busy` is high is ignored: it starts no transaction and does not change the address or mode in use.
- R9: After reset, `spi_cs_n`=1, `spi_clk`=0, `busy`=0, `done`=0 and `timed_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin an erase sequence |
| addr | input | 32 | Any address inside the target subsector |
| four_byte | input | 1 | 1: send 32 address bits; 0: send 24 |
| fixed_wait | input | 1 | 1: wait `wait_cycles` clocks; 0: poll status |
| poll_limit | input | POLL_W | Maximum number of status reads |
| wait_cycles | input | WAIT_W | Fixed-wait length in system clocks |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | Last sequence hit the poll limit |
| spi_clk | output | 1 | Serial clock to the flash |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial command/address line |
| spi_miso | input | 1 | Serial status line from the flash |

## Verification
The flash can report write-in-progress cleared on the very read that exhausts the poll limit, so the completion decision and the timeout decision fall in the same cycle. A flash model in the bench returns the busy bit for a programmed number of reads. One vector sets that number to one less than the limit, and its neighbour sets it equal to the limit. The first must finish with the full number of reads and no timeout flag. The second must make the same number of reads and raise the flag. A second overlap is a new start arriving while a sequence runs. It is judged by the address and transaction count the flash model logs afterwards.

// File: rtl/ssec_pkg.sv
// Shared constants and state types for the subsector erase sequencer.
// Assumes a left-aligned 40-bit frame: 8 opcode bits plus up to 32 address bits.
package ssec_pkg;
    localparam int FRAME_BITS = 40;
    localparam int NBIT_W     = $clog2(FRAME_BITS + 1);

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_SUBERA = 8'h20;
    localparam logic [7:0] OP_RDSR   = 8'h05;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_WREN, SQ_ERASE, SQ_POLL, SQ_WAIT, SQ_FIN
    } seq_st_t;

    typedef enum logic [1:0] {
        EN_IDLE, EN_LOW, EN_HIGH, EN_GAP
    } eng_st_t;
endpackage

// File: rtl/ssec_shift_eng.sv
// Serial shift engine: runs one chip-select transaction of nbits serial clocks.
// It shifts the frame out MSB first, changing mosi while sclk is low.
// It samples miso as sclk rises and keeps the last sampled bit.
// It then holds chip select high for GAP_CYC clocks before reporting fin.
// Assumes CLK_DIV >= 1, GAP_CYC >= 1, and that go is only raised while ready.
module ssec_shift_eng
    import ssec_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int GAP_CYC = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic [NBIT_W-1:0]     nbits,
    output logic                  ready,
    output logic                  fin,
    output logic                  rx_bit,
    output logic                  sclk,
    output logic                  cs_n,
    output logic                  mosi,
    input  logic                  miso
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    eng_st_t               st;
    logic [FRAME_BITS-1:0] sh;
    logic [NBIT_W-1:0]     left;
    logic [DIV_W-1:0]      div;
    logic [GAP_W-1:0]      gcnt;
    logic                  half_end;

    assign half_end = (div == DIV_W'(CLK_DIV - 1));
    assign ready    = (st == EN_IDLE);

    // Transaction phase machine: half-period timing, shifting, sampling, gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= EN_IDLE;
            sh     <= '0;
            left   <= '0;
            div    <= '0;
            gcnt   <= '0;
            sclk   <= 1'b0;
            cs_n   <= 1'b1;
            mosi   <= 1'b0;
            rx_bit <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (st)
                EN_IDLE: begin
                    if (go) begin
                        sh   <= frame;
                        left <= nbits;
                        cs_n <= 1'b0;
                        mosi <= frame[FRAME_BITS-1];
                        div  <= '0;
                        st   <= EN_LOW;
                    end
                end
                EN_LOW: begin
                    if (half_end) begin
                        div    <= '0;
                        sclk   <= 1'b1;
                        rx_bit <= miso;
                        st     <= EN_HIGH;
                    end else begin
                        div <= div + DIV_W'(1);
                    end
                end
                EN_HIGH: begin
                    if (half_end) begin
                        div  <= '0;
                        sclk <= 1'b0;
                        if (left == NBIT_W'(1)) begin
                            cs_n <= 1'b1;
                            mosi <= 1'b0;
                            gcnt <= '0;
                            st   <= EN_GAP;
                        end else begin
                            left <= left - NBIT_W'(1);
                            sh   <= sh << 1;
                            mosi <= sh[FRAME_BITS-2];
                            st   <= EN_LOW;
                        end
                    end else begin
                        div <= div + DIV_W'(1);
                    end
                end
                EN_GAP: begin
                    if (gcnt == GAP_W'(GAP_CYC - 1)) begin
                        st  <= EN_IDLE;
                        fin <= 1'b1;
                    end else begin
                        gcnt <= gcnt + GAP_W'(1);
                    end
                end
                default: st <= EN_IDLE;
            endcase
        end
    end

    // Checker counter: chip-select high time, saturating at GAP_CYC.
    logic [GAP_W-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= GAP_W'(GAP_CYC);
        else if (!cs_n)
            hi_cnt <= '0;
        else if (hi_cnt != GAP_W'(GAP_CYC))
            hi_cnt <= hi_cnt + GAP_W'(1);
    end

    // R3
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));
    // R4
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= GAP_W'(GAP_CYC)));
endmodule

// File: rtl/ssec_ctrl.sv
// Sequence controller: write enable, then the subsector erase, then either status polling or a fixed wait.
// It captures address, mode and poll limit at start and ignores start while busy.
// Assumes the engine's rx_bit at fin is the last status bit, which is write-in-progress.
module ssec_ctrl
    import ssec_pkg::*;
#(
    parameter int POLL_W = 16,
    parameter int WAIT_W = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [31:0]           addr,
    input  logic                  four_byte,
    input  logic                  fixed_wait,
    input  logic [POLL_W-1:0]     poll_limit,
    input  logic [WAIT_W-1:0]     wait_cycles,
    input  logic                  eng_ready,
    input  logic                  eng_fin,
    input  logic                  eng_rx_bit,
    output logic                  eng_go,
    output logic [FRAME_BITS-1:0] eng_frame,
    output logic [NBIT_W-1:0]     eng_nbits,
    output logic                  busy,
    output logic                  done,
    output logic                  timed_out
);
    seq_st_t           st;
    logic              launched;
    logic [31:0]       lat_addr;
    logic              lat_4b;
    logic              lat_fw;
    logic [POLL_W-1:0] lat_lim;
    logic [POLL_W-1:0] polls;
    logic [POLL_W:0]   polls_nx;
    logic [POLL_W:0]   lim_eff;
    logic [WAIT_W-1:0] wcnt;
    logic              issue;

    assign busy     = (st != SEQ_IDLE_C);
    assign polls_nx = {1'b0, polls} + (POLL_W+1)'(1);
    assign lim_eff  = (lat_lim == '0) ? (POLL_W+1)'(1) : {1'b0, lat_lim};
    assign issue    = !launched && eng_ready;

    localparam seq_st_t SEQ_IDLE_C = SQ_IDLE;

    // Main sequence: launch each transaction once and advance on its fin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SQ_IDLE;
            launched  <= 1'b0;
            lat_addr  <= '0;
            lat_4b    <= 1'b0;
            lat_fw    <= 1'b0;
            lat_lim   <= '0;
            polls     <= '0;
            wcnt      <= '0;
            eng_go    <= 1'b0;
            eng_frame <= '0;
            eng_nbits <= '0;
            done      <= 1'b0;
            timed_out <= 1'b0;
        end else begin
            eng_go <= 1'b0;
            done   <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        lat_addr  <= addr;
                        lat_4b    <= four_byte;
                        lat_fw    <= fixed_wait;
                        lat_lim   <= poll_limit;
                        polls     <= '0;
                        timed_out <= 1'b0;
                        st        <= SQ_WREN;
                    end
                end
                SQ_WREN: begin
                    if (issue) begin
                        eng_frame <= {OP_WREN, 32'h0};
                        eng_nbits <= NBIT_W'(8);
                        eng_go    <= 1'b1;
                        launched  <= 1'b1;
                    end else if (launched && eng_fin) begin
                        launched <= 1'b0;
                        st       <= SQ_ERASE;
                    end
                end
                SQ_ERASE: begin
                    if (issue) begin
                        eng_frame <= lat_4b ? {OP_SUBERA, lat_addr}
                                            : {OP_SUBERA, lat_addr[23:0], 8'h0};
                        eng_nbits <= lat_4b ? NBIT_W'(40) : NBIT_W'(32);
                        eng_go    <= 1'b1;
                        launched  <= 1'b1;
                    end else if (launched && eng_fin) begin
                        launched <= 1'b0;
                        wcnt     <= '0;
                        st       <= lat_fw ? SQ_WAIT : SQ_POLL;
                    end
                end
                SQ_POLL: begin
                    if (issue) begin
                        eng_frame <= {OP_RDSR, 32'h0};
                        eng_nbits <= NBIT_W'(16);
                        eng_go    <= 1'b1;
                        launched  <= 1'b1;
                    end else if (launched && eng_fin) begin
                        launched <= 1'b0;
                        polls    <= polls_nx[POLL_W-1:0];
                        if (!eng_rx_bit) begin
                            st <= SQ_FIN;
                        end else if (polls_nx >= lim_eff) begin
                            timed_out <= 1'b1;
                            st        <= SQ_FIN;
                        end
                    end
                end
                SQ_WAIT: begin
                    if (wcnt >= wait_cycles) st <= SQ_FIN;
                    else                     wcnt <= wcnt + WAIT_W'(1);
                end
                SQ_FIN: begin
                    done <= 1'b1;
                    st   <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // R1
    wren_then_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_WREN && launched && eng_fin) |=> (st == SQ_ERASE));
    // R6
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, polls} <= lim_eff));
    // R7
    fixed_no_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lat_fw) |-> (st != SQ_POLL));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(lat_addr));
    // R3
    go_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |-> eng_ready);
endmodule

// File: rtl/ssec_erase_seq.sv
// Top of the subsector erase sequencer: joins the sequence controller to the serial shift engine.
// Assumes start is a one-cycle pulse and that the mode inputs are valid with it.
module ssec_erase_seq
    import ssec_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int GAP_CYC = 4,
    parameter int POLL_W  = 16,
    parameter int WAIT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       addr,
    input  logic              four_byte,
    input  logic              fixed_wait,
    input  logic [POLL_W-1:0] poll_limit,
    input  logic [WAIT_W-1:0] wait_cycles,
    output logic              busy,
    output logic              done,
    output logic              timed_out,
    output logic              spi_clk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic                  go;
    logic [FRAME_BITS-1:0] frame;
    logic [NBIT_W-1:0]     nbits;
    logic                  ready;
    logic                  fin;
    logic                  rx_bit;

    ssec_ctrl #(.POLL_W(POLL_W), .WAIT_W(WAIT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .addr       (addr),
        .four_byte  (four_byte),
        .fixed_wait (fixed_wait),
        .poll_limit (poll_limit),
        .wait_cycles(wait_cycles),
        .eng_ready  (ready),
        .eng_fin    (fin),
        .eng_rx_bit (rx_bit),
        .eng_go     (go),
        .eng_frame  (frame),
        .eng_nbits  (nbits),
        .busy       (busy),
        .done       (done),
        .timed_out  (timed_out)
    );

    ssec_shift_eng #(.CLK_DIV(CLK_DIV), .GAP_CYC(GAP_CYC)) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .frame  (frame),
        .nbits  (nbits),
        .ready  (ready),
        .fin    (fin),
        .rx_bit (rx_bit),
        .sclk   (spi_clk),
        .cs_n   (spi_cs_n),
        .mosi   (spi_mosi),
        .miso   (spi_miso)
    );
endmodule

// File: tb/ssec_erase_seq_test.sv
`timescale 1ns/1ps
// Bench: a flash model logs each transaction and answers status reads.
// A vector table drives the main runs, and directed tests follow.
module ssec_erase_seq_test;
    localparam int GAP  = 4;
    localparam int WAIT = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] addr = '0;
    logic        four_byte = 1'b0;
    logic        fixed_wait = 1'b0;
    logic [15:0] poll_limit = '0;
    logic [23:0] wait_cycles = 24'(WAIT);
    logic        busy, done, timed_out, spi_clk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    ssec_erase_seq #(.CLK_DIV(2), .GAP_CYC(GAP), .POLL_W(16), .WAIT_W(24)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr),
        .four_byte(four_byte), .fixed_wait(fixed_wait),
        .poll_limit(poll_limit), .wait_cycles(wait_cycles),
        .busy(busy), .done(done), .timed_out(timed_out),
        .spi_clk(spi_clk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc++;

    // Flash model state
    logic [63:0] mshift = '0;
    logic [7:0]  cur_op = '0;
    int          bitc = 0;
    int          n_tx = 0;
    int          wip_cfg = 0;
    int          wip_left = 0;
    int          erase_end = 0;
    int          rise_cyc = -1;
    int          min_gap = 1000000;
    logic [7:0]  log_op [16];
    int          log_bits [16];
    logic [31:0] log_addr [16];

    always @(negedge spi_cs_n) begin
        if (rise_cyc >= 0 && (cyc - rise_cyc) < min_gap) min_gap = cyc - rise_cyc;
        bitc = 0; mshift = '0; cur_op = '0;
    end
    always @(posedge spi_clk) begin
        if (!spi_cs_n) begin
            mshift = {mshift[62:0], spi_mosi};
            bitc++;
            if (bitc == 8) cur_op = mshift[7:0];
        end
    end
    always @(negedge spi_clk) begin
        logic [7:0] stb;
        stb = {7'b0, (wip_left > 0)};
        if (!spi_cs_n && cur_op == 8'h05 && bitc >= 8 && bitc < 16)
            spi_miso = stb[15 - bitc];
    end
    always @(posedge spi_cs_n) begin
        if (bitc > 0) begin
            if (n_tx < 16) begin
                log_op[n_tx]   = cur_op;
                log_bits[n_tx] = bitc;
                log_addr[n_tx] = (bitc == 40) ? mshift[31:0] :
                                 (bitc == 32) ? {8'h0, mshift[23:0]} : 32'h0;
            end
            if (cur_op == 8'h20) begin wip_left = wip_cfg; erase_end = cyc; end
            if (cur_op == 8'h05 && wip_left > 0) wip_left--;
            n_tx++;
            rise_cyc = cyc;
            bitc = 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [31:0] a, input logic fb,
                               input logic fw, input logic [15:0] lim);
        @(negedge clk);
        addr = a; four_byte = fb; fixed_wait = fw; poll_limit = lim; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int at);
        do @(negedge clk); while (!done);
        at = cyc;
    endtask

    typedef struct packed {
        logic [31:0] a;
        logic        fb;
        logic        fw;
        logic [7:0]  wip;
        logic [15:0] lim;
        logic [7:0]  rd;
        logic        to;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h00AB_CDEF, 1'b0, 1'b0, 8'd3, 16'd10, 8'd4, 1'b0},
        '{32'h1234_5678, 1'b1, 1'b0, 8'd0, 16'd5,  8'd1, 1'b0},
        '{32'hFEDC_BA98, 1'b1, 1'b0, 8'd6, 16'd6,  8'd6, 1'b1},
        '{32'h0000_0FFF, 1'b0, 1'b0, 8'd5, 16'd6,  8'd6, 1'b0},
        '{32'h8000_0001, 1'b0, 1'b0, 8'd2, 16'd0,  8'd1, 1'b1},
        '{32'hA5A5_5A5A, 1'b1, 1'b1, 8'd9, 16'd3,  8'd0, 1'b0}
    };

    initial begin
        #(150000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int t_done;
        repeat (5) @(negedge clk);
        // R9 reset state
        check(spi_cs_n == 1'b1 && spi_clk == 1'b0, "R9", "cs/clk at reset", {spi_cs_n, spi_clk}, 2'b10);
        check(busy == 1'b0 && done == 1'b0 && timed_out == 1'b0, "R9", "busy/done/to", {busy, done, timed_out}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int i = 0; i < 6; i++) begin
            vec_t v;
            logic [31:0] ea;
            v = VECS[i];
            ea = v.fb ? v.a : {8'h0, v.a[23:0]};
            wip_cfg = int'(v.wip); n_tx = 0; min_gap = 1000000;
            pulse_start(v.a, v.fb, v.fw, v.lim);
            check(busy == 1'b1, "R8", "busy after start", busy, 1);
            check(timed_out == 1'b0, "R6", "flag cleared by start", timed_out, 0);
            wait_done(t_done);
            check(busy == 1'b0, "R8", "busy low with done", busy, 0);
            check(n_tx == 2 + int'(v.rd), "R5", "transaction count", n_tx, 2 + int'(v.rd));
            check(log_op[0] == 8'h06 && log_bits[0] == 8, "R1", "write enable frame",
                  {log_op[0], 8'(log_bits[0])}, 16'h0608);
            check(log_op[1] == 8'h20, "R2", "erase opcode", log_op[1], 8'h20);
            check(log_bits[1] == (v.fb ? 40 : 32), "R3", "erase clock count", log_bits[1], v.fb ? 40 : 32);
            check(log_addr[1] == ea, "R2", "erase address", log_addr[1], ea);
            for (int k = 2; k < n_tx && k < 16; k++)
                check(log_op[k] == 8'h05 && log_bits[k] == 16, "R5", "status read frame",
                      {log_op[k], 8'(log_bits[k])}, 16'h0510);
            check(min_gap >= GAP, "R4", "chip select gap", min_gap, GAP);
            if (v.fw)
                check((t_done - erase_end) >= WAIT && (t_done - erase_end) <= WAIT + GAP + 10,
                      "R7", "fixed wait length", t_done - erase_end, WAIT);
            repeat (3) @(negedge clk);
            check(timed_out == v.to, "R6", "timeout flag held", timed_out, v.to);
            check(spi_clk == 1'b0 && spi_cs_n == 1'b1, "R3", "idle serial lines",
                  {spi_cs_n, spi_clk}, 2'b10);
        end

        // R8 directed: a start during a run is ignored
        wip_cfg = 1; n_tx = 0;
        pulse_start(32'h0011_1111, 1'b0, 1'b0, 16'd4);
        repeat (40) @(negedge clk);
        pulse_start(32'h00FF_FF00, 1'b1, 1'b1, 16'd1);
        wait_done(t_done);
        check(log_addr[1] == 32'h0011_1111 && log_bits[1] == 32, "R8", "address kept",
              log_addr[1], 32'h0011_1111);
        check(n_tx == 4, "R8", "transactions with ignored start", n_tx, 4);
        repeat (60) @(negedge clk);
        check(n_tx == 4 && busy == 1'b0, "R8", "no second run", n_tx, 4);

        // R9 reset mid-run returns to idle
        pulse_start(32'h0000_0100, 1'b0, 1'b0, 16'd2);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(spi_cs_n == 1'b1 && spi_clk == 1'b0 && busy == 1'b0, "R9", "reset mid-run",
              {spi_cs_n, spi_clk, busy}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule